// File: doc/BRIEF.md
# DMA Channel Interrupt Register Block

This block keeps the interrupt state of a single DMA channel. Twelve event sources, each arriving as a one-cycle pulse, latch into a 12-bit status register. A 12-bit mask register decides which latched events may drive the single level interrupt line. Software clears status bits by writing ones to them. Software cannot write the mask directly. It clears mask bits through an unmask register and sets them through a mask-set register.

Two 8-bit accounting counters track descriptor completions that asked for an interrupt, one for the source side and one for the destination side. Reading a counter returns its value and clears it. When a counter wraps past its largest value, a dedicated error bit in the status register is set. An access to a word address that selects no register is also recorded in the status register.

The register port takes one access per cycle. The address is a word index, so byte offset divided by four. Read data is registered.

Top module: `dma_irq_regs`

Register selection by word index: 0 status, 1 mask (read-only), 2 unmask, 3 mask-set, 4 source counter, 5 destination counter. Every other index is undecoded. Each decoded access resolves to one selector value: STATUS, MASK, UNMASK, MASKSET, SRC_CNT, DST_CNT or NONE.

## Requirements
- R1: After reset, status is 0, mask is 0xFFF, both counters are 0, `irq` is low and `rsp_rdata` is 0.
- R2: A pulse on `evt_pulse[i]` sets status bit i. Writing a 1 to bit i at word 0 clears status bit i, and writing 0 leaves it unchanged. Status bits 31..12 read as zero. The bit meanings are: 0 bad access, 1 source descriptor done, 2 destination descriptor done, 3 byte count overflow, 4 source accounting wrap, 5 destination accounting wrap, 6/7 source/destination descriptor fetch error, 8/9 data read/write error, 10 transfer done, 11 paused.
- R3: A write to word 0 that clears bit i, in the same cycle as a pulse on `evt_pulse[i]`, leaves bit i set.
- R4: Mask changes only through two registers. Writing a 1 to bit i at word 2 clears mask bit i. Writing a 1 to bit i at word 3 sets mask bit i. A write to word 1 has no effect. Words 2 and 3 read as zero, and word 1 returns the mask.
- R5: `irq` is high exactly when some status bit is set and its mask bit is clear. It reflects the state after each clock edge.
- R6: `evt_pulse[1]` increments the source counter (word 4) and `evt_pulse[2]` increments the destination counter (word 5). An increment from 255 gives 0 and sets status bit 4 (source) or status bit 5 (destination).
- R7: A read of a counter returns its value and clears it. A write to a counter has no effect. If a read and an increment of the same counter coincide, the read returns the old value and the counter becomes 1.
- R8: Any read or write to an undecoded word index sets status bit 0. A read of such an index returns 0.
- R9: Read data appears on `rsp_rdata` after the clock edge that accepts the read. It holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word index of the register |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Registered read data |
| evt_pulse | input | 12 | One-cycle event pulses, bit i sets status bit i |
| irq | output | 1 | Level interrupt request |

## Verification
The embedded properties assume the inputs carry no unknown values after reset. They also assume an unmask write and a mask-set write never reach the same bit in the same cycle. The port guarantees this, because one access addresses one register. The properties on clearing and counting each exclude a coinciding event or read, and separate properties cover those coincidences. The bench drives all inputs on the falling edge and issues at most one access per cycle. It deliberately places events, clears and counter reads in the same cycles, so the priority cases are exercised and not avoided.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int unsigned NUM_EVT          = 12;
    localparam int unsigned BIT_BAD_ACCESS   = 0;
    localparam int unsigned BIT_SRC_DONE     = 1;
    localparam int unsigned BIT_SRC_ACCT_ERR = 4;
    localparam int unsigned NUM_ACCT         = 2;

    typedef enum logic [2:0] {
        SEL_STATUS,
        SEL_MASK,
        SEL_UNMASK,
        SEL_MASKSET,
        SEL_SRC_CNT,
        SEL_DST_CNT,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_word(input int unsigned idx);
        reg_sel_e s;
        unique case (idx)
            0:       s = SEL_STATUS;
            1:       s = SEL_MASK;
            2:       s = SEL_UNMASK;
            3:       s = SEL_MASKSET;
            4:       s = SEL_SRC_CNT;
            5:       s = SEL_DST_CNT;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int unsigned N = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] unmask_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] status_o,
    output logic [N-1:0] mask_o,
    output logic         irq_o
);

    logic [N-1:0] status_q, status_d;
    logic [N-1:0] mask_q, mask_d;

    // new events override a same-cycle clear
    always_comb begin
        status_d = (status_q & ~clr_i) | set_i;
        mask_d   = (mask_q & ~unmask_i) | mask_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '1;
        end else begin
            status_q <= status_d;
            mask_q   <= mask_d;
        end
    end

    always_comb begin
        status_o = status_q;
        mask_o   = mask_q;
        irq_o    = |(status_q & ~mask_q);
    end

    AST_UNMASKED_EVENT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & ~mask_q & ~mask_i)) |=> irq_o); // R5

    for (genvar b = 0; b < N; b++) begin : g_bit_chk
        AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[b] |=> status_q[b]); // R3
        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[b] && !set_i[b]) |=> !status_q[b]); // R2
        AST_MASKSET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            mask_i[b] |=> mask_q[b]); // R4
        AST_UNMASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (unmask_i[b] && !mask_i[b]) |=> !mask_q[b]); // R4
    end

endmodule

// File: rtl/acct_counter.sv
module acct_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         rd_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);

    localparam logic [W-1:0] CNT_MAX = '1;
    localparam logic [W-1:0] CNT_ONE = W'(1);

    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        if (rd_i)
            cnt_d = inc_i ? CNT_ONE : '0;
        else if (inc_i)
            cnt_d = cnt_q + CNT_ONE;
        else
            cnt_d = cnt_q;
        wrap_o = inc_i && !rd_i && (cnt_q == CNT_MAX);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !inc_i) |=> (cnt_q == '0)); // R7
    AST_READ_INC_RACE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && inc_i) |=> (cnt_q == CNT_ONE)); // R7
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_q == '0)); // R6
    AST_PLAIN_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !rd_i) |=> (cnt_q == W'($past(cnt_q) + CNT_ONE))); // R6

endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
    import dma_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic [DATA_W-1:0]  rsp_rdata,
    input  logic [NUM_EVT-1:0] evt_pulse,
    output logic               irq
);

    localparam int unsigned HI_W = DATA_W - NUM_EVT;

    reg_sel_e             sel;
    logic                 rd_en, wr_en, bad_acc;
    logic [NUM_EVT-1:0]   wbits;
    logic [NUM_EVT-1:0]   set_vec, clr_vec, unmask_vec, maskset_vec;
    logic [NUM_EVT-1:0]   status_vec, mask_vec;
    logic [NUM_ACCT-1:0]  wrap_vec;
    logic [NUM_ACCT-1:0][CNT_W-1:0] cnt_vec;
    logic [DATA_W-1:0]    rd_val, rdata_q;
    logic                 unused_wdata_hi;

    assign sel             = decode_word(int'(req_addr));
    assign rd_en           = req_valid && !req_write;
    assign wr_en           = req_valid && req_write;
    assign bad_acc         = req_valid && (sel == SEL_NONE);
    assign wbits           = req_wdata[NUM_EVT-1:0];
    assign unused_wdata_hi = ^req_wdata[DATA_W-1:DATA_W-HI_W];

    always_comb begin
        clr_vec     = (wr_en && sel == SEL_STATUS)  ? wbits : '0;
        unmask_vec  = (wr_en && sel == SEL_UNMASK)  ? wbits : '0;
        maskset_vec = (wr_en && sel == SEL_MASKSET) ? wbits : '0;
        set_vec     = evt_pulse;
        set_vec[BIT_BAD_ACCESS] = set_vec[BIT_BAD_ACCESS] | bad_acc;
        for (int k = 0; k < NUM_ACCT; k++)
            set_vec[BIT_SRC_ACCT_ERR + k] = set_vec[BIT_SRC_ACCT_ERR + k] | wrap_vec[k];
    end

    irq_status_bank #(.N(NUM_EVT)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_vec),
        .clr_i    (clr_vec),
        .unmask_i (unmask_vec),
        .mask_i   (maskset_vec),
        .status_o (status_vec),
        .mask_o   (mask_vec),
        .irq_o    (irq)
    );

    for (genvar k = 0; k < NUM_ACCT; k++) begin : g_acct
        localparam reg_sel_e KSEL = (k == 0) ? SEL_SRC_CNT : SEL_DST_CNT;
        logic rd_k;
        assign rd_k = rd_en && (sel == KSEL);
        acct_counter #(.W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc_i  (evt_pulse[BIT_SRC_DONE + k]),
            .rd_i   (rd_k),
            .cnt_o  (cnt_vec[k]),
            .wrap_o (wrap_vec[k])
        );
    end

    always_comb begin
        unique case (sel)
            SEL_STATUS:  rd_val = DATA_W'(status_vec);
            SEL_MASK:    rd_val = DATA_W'(mask_vec);
            SEL_SRC_CNT: rd_val = DATA_W'(cnt_vec[0]);
            SEL_DST_CNT: rd_val = DATA_W'(cnt_vec[1]);
            default:     rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_val;
    end

    assign rsp_rdata = rdata_q;

    AST_BAD_ADDR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        bad_acc |=> status_vec[BIT_BAD_ACCESS]); // R8
    AST_BAD_ADDR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_acc && !req_write) |=> (rsp_rdata == '0)); // R8
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rsp_rdata)); // R9

endmodule

// File: tb/dma_irq_regs_test.sv
module dma_irq_regs_test;

    localparam int CLK_NS = 10;
    localparam int AW     = 8;
    localparam int DW     = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [11:0]   evt_pulse = '0;
    logic [DW-1:0] rsp_rdata;
    logic          irq;

    always #(CLK_NS/2) clk = ~clk;

    dma_irq_regs uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .evt_pulse(evt_pulse), .irq(irq)
    );

    // behavioural reference state
    logic [31:0] m_status = 0, m_mask = 32'hFFF, m_rdata = 0;
    int          m_cs = 0, m_cd = 0;
    int          vectors = 0, miscmp = 0;
    string       last_tag = "R1";
    bit          done = 0;

    task automatic compare();
        logic exp_irq;
        exp_irq = ((m_status & ~m_mask & 32'hFFF) != 0);
        vectors++;
        if (irq !== exp_irq) begin
            miscmp++;
            $display("FAIL %s/R5 irq actual=%0b expected=%0b t=%0t", last_tag, irq, exp_irq, $time);
        end
        vectors++;
        if (rsp_rdata !== m_rdata) begin
            miscmp++;
            $display("FAIL %s/R9 rdata actual=%08h expected=%08h t=%0t", last_tag, rsp_rdata, m_rdata, $time);
        end
    endtask

    task automatic model(bit v, bit w, int a, logic [31:0] d, logic [11:0] e);
        bit rd = v && !w;
        bit wr = v && w;
        bit bad = v && (a > 5);
        bit ws = 0, wd = 0;
        logic [31:0] clr = 0, set;
        if (rd) begin
            case (a)
                0: m_rdata = m_status;
                1: m_rdata = m_mask;
                4: m_rdata = m_cs;
                5: m_rdata = m_cd;
                default: m_rdata = 0;
            endcase
        end
        if (rd && a == 4) m_cs = e[1] ? 1 : 0;
        else if (e[1]) begin
            if (m_cs == 255) begin m_cs = 0; ws = 1; end else m_cs++;
        end
        if (rd && a == 5) m_cd = e[2] ? 1 : 0;
        else if (e[2]) begin
            if (m_cd == 255) begin m_cd = 0; wd = 1; end else m_cd++;
        end
        if (wr && a == 0) clr = d & 32'hFFF;
        if (wr && a == 2) m_mask = m_mask & ~d & 32'hFFF;
        if (wr && a == 3) m_mask = (m_mask | d) & 32'hFFF;
        set = {20'd0, e} | {31'd0, bad} | (32'(ws) << 4) | (32'(wd) << 5);
        m_status = ((m_status & ~clr) | set) & 32'hFFF;
    endtask

    task automatic step(bit v, bit w, int a, logic [31:0] d, logic [11:0] e, string tag);
        @(negedge clk);
        compare();
        req_valid = v; req_write = w; req_addr = AW'(a); req_wdata = d; evt_pulse = e;
        model(v, w, a, d, e);
        last_tag = tag;
    endtask

    task automatic idle(string tag);   step(0, 0, 0, 0, 0, tag); endtask
    task automatic rd(int a, string tag); step(1, 0, a, 0, 0, tag); endtask
    task automatic wr(int a, logic [31:0] d, string tag); step(1, 1, a, d, 0, tag); endtask
    task automatic ev(logic [11:0] e, string tag); step(0, 0, 0, 0, e, tag); endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            miscmp++;
            vectors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1");
        // R1: reset values visible through reads
        rd(0, "R1"); rd(1, "R1"); rd(4, "R1"); rd(5, "R1"); rd(2, "R4"); rd(3, "R4");
        // R2 + R5: masked event stays silent
        ev(12'h400, "R2"); rd(0, "R2");
        // R4: unmask raises irq
        wr(2, 32'h400, "R4"); rd(1, "R4");
        wr(1, 32'h0, "R4"); rd(1, "R4");           // direct mask write ignored
        // R2: write-one-to-clear, upper bits read zero
        wr(0, 32'hFFFF_F000, "R2"); rd(0, "R2");
        wr(0, 32'hFFFF_F400, "R2"); rd(0, "R2");
        // R3: event and clear on the same bit in the same cycle
        ev(12'h400, "R3");
        step(1, 1, 0, 32'h400, 12'h400, "R3"); rd(0, "R3");
        wr(3, 32'h400, "R4"); rd(1, "R4");          // mask again
        // R6/R7: counting and clear on read
        ev(12'h002, "R6"); ev(12'h002, "R6"); ev(12'h006, "R6");
        rd(4, "R7"); rd(4, "R7"); rd(5, "R7"); rd(5, "R7");
        // R7: read colliding with increment
        ev(12'h002, "R7"); ev(12'h002, "R7");
        step(1, 0, 4, 0, 12'h002, "R7"); rd(4, "R7");
        // R7: write to counter ignored
        ev(12'h004, "R7"); wr(5, 32'h0, "R7"); wr(5, 32'hFF, "R7"); rd(5, "R7");
        // R6: destination wrap sets bit 5
        wr(2, 32'h030, "R6");
        wr(0, 32'hFFF, "R6");
        for (int i = 0; i < 256; i++) ev(12'h004, "R6");
        rd(0, "R6"); rd(5, "R6");
        for (int i = 0; i < 256; i++) ev(12'h002, "R6");
        rd(0, "R6"); rd(4, "R6");
        wr(0, 32'h030, "R2");
        // R8: undecoded accesses
        wr(2, 32'h001, "R8");
        rd(0, "R8");
        rd(6, "R8"); rd(0, "R8");
        wr(0, 32'h001, "R8");
        wr(200, 32'hFFFF_FFFF, "R8"); rd(0, "R8");
        rd(255, "R8");
        // R9: read data holds across idle cycles
        rd(1, "R9"); idle("R9"); idle("R9"); ev(12'hFFF, "R9"); idle("R9");
        // mixed traffic
        for (int i = 0; i < 3000; i++) begin
            int a;
            logic [11:0] e;
            a = ($urandom % 10 == 0) ? 6 + ($urandom % 250) : ($urandom % 6);
            e = ($urandom % 3 == 0) ? 12'($urandom) : 12'h0;
            step(($urandom % 2) == 1, ($urandom % 2) == 1, a, $urandom, e, "R5");
        end
        idle("R5");
        @(negedge clk);
        compare();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

endmodule